// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits between a set of peripheral interrupt sources and a small CPU sequencer. Edge-type sources each own a latched request flag. Level-type sources have no flag and request only while their condition is held. Every source has an enable bit held inside the block, and a single global enable gates all of them. When the CPU reaches an instruction boundary, the controller picks the pending request with the smallest vector number. It pulses an acknowledge carrying that vector number, clears the global enable and runs the entry sequence.

Vector 0 is reserved for reset and is never issued. The edge-type sources take vectors 1 to NUM_EDGE. The level-type sources follow them, in the order of their bit positions. The CPU signals a return from a handler with a strobe. The controller then runs a fixed-length return sequence, pulses the stack-pop strobe and sets the global enable again when the sequence ends. Software writes the enable bits as a whole word. It clears flags by writing ones to their positions.

Top module: `vpic_ctrl`

## Requirements
- R1: Of all enabled pending requests, the one with the lowest vector number is accepted. Edge source bit i has vector i+1. Level source bit j has vector NUM_EDGE+1+j. Vector 0 is never issued.
- R2: Acceptance happens on a clock edge. In the cycle after that edge, `irq_ack` is high for exactly one cycle, `irq_vec` holds the accepted vector and `gie` reads 0.
- R3: An accepted edge source has its flag cleared. A one written on `flag_clr` clears that flag and a zero leaves it as it was. An event arriving in the same cycle as a clear leaves the flag set.
- R4: An edge event sets its flag even while its enable or the global enable is clear. The flag is accepted once both enables are set.
- R5: A level request that is removed before its enable is set never causes an acceptance. A level request that is present while enabled is accepted.
- R6: After `gie_set` at an instruction boundary, no request is accepted at that boundary. Acceptance can first happen at the next boundary, so exactly one instruction runs first. A return behaves the same way: `gie` rises only when the return sequence ends.
- R7: `gie_clr` blocks any acceptance in its own cycle and clears `gie`.
- R8: The entry sequence keeps `seq_busy` high for ENTRY_CYC cycles, or for ENTRY_CYC+WAKE_CYC cycles when accepted from sleep. `vec_go` pulses in the last of those cycles.
- R9: A return keeps `seq_busy` high for RET_CYC cycles. `sp_pop` is high in the first two of them, and `gie` is 1 after the sequence ends.
- R10: While `mc_busy` is high and the CPU is awake, no request is accepted. The request is accepted at the first boundary where `mc_busy` is low.
- R11: After reset, `gie`, all flags, all enables, `irq_ack` and `seq_busy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_edge | input | NUM_EDGE | Event pulses for the flagged sources |
| src_level | input | NUM_LEVEL | Condition inputs for the unflagged sources |
| en_we | input | 1 | Write strobe for the enable word |
| en_wdata | input | NUM_EDGE+NUM_LEVEL | New enable word (edge bits low, level bits high) |
| flag_clr | input | NUM_EDGE | Write-one-to-clear for the flags |
| insn_end | input | 1 | An instruction completes in this cycle |
| mc_busy | input | 1 | A multi-cycle instruction is still running |
| sleeping | input | 1 | The CPU is asleep and may be woken by a request |
| gie_set | input | 1 | An instruction sets the global enable |
| gie_clr | input | 1 | An instruction clears the global enable |
| reti | input | 1 | A return-from-handler instruction starts |
| irq_ack | output | 1 | One-cycle pulse that marks an acceptance |
| irq_vec | output | $clog2(NUM_EDGE+NUM_LEVEL+1) | Vector number of the last acceptance |
| seq_busy | output | 1 | An entry or return sequence is running |
| vec_go | output | 1 | Last entry cycle; the handler starts next |
| sp_pop | output | 1 | One stack byte is popped in this cycle |
| gie | output | 1 | Global enable state |
| flags | output | NUM_EDGE | Current edge flags |

## Verification
The assertions assume that the CPU raises `reti` only while no sequence is running. They also assume that `gie_set` is never raised in the same cycle as `gie_clr`, and that `insn_end` means a whole instruction has just retired. The stimulus drives `reti` only after `seq_busy` has fallen, and it raises each global-enable strobe on its own. Level inputs are held steady across the whole of each acceptance window, so the recorded vector always matches a request that is still present.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_ENTRY, PH_RET} phase_t;

  // Length of the entry sequence; waking from sleep adds the extra cycles
  function automatic int unsigned entry_len(int unsigned base, int unsigned extra, logic wake);
    return base + (wake ? extra : 0);
  endfunction
endpackage

// File: rtl/vpic_flags.sv
module vpic_flags #(
  parameter int unsigned NE = 3,
  parameter int unsigned NL = 2,
  localparam int unsigned NS = NE + NL
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NE-1:0] src_edge,
  input  logic [NL-1:0] src_level,
  input  logic [NE-1:0] flag_clr,
  input  logic          en_we,
  input  logic [NS-1:0] en_wdata,
  input  logic [NS-1:0] acc_oh,
  output logic [NE-1:0] flag_q,
  output logic [NS-1:0] req
);
  logic [NS-1:0] en_q;
  logic [NE-1:0] acc_edge;

  assign acc_edge = acc_oh[NE-1:0];

  // a new event wins over every clear arriving in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
    end else begin
      flag_q <= (flag_q & ~flag_clr & ~acc_edge) | src_edge;
      if (en_we) en_q <= en_wdata;
    end
  end

  assign req = en_q & {src_level, flag_q};

  assert_acc_clears_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(acc_edge & ~src_edge)) |=> ((flag_q & $past(acc_edge & ~src_edge)) == '0));

  assert_event_latched_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_edge) |=> ((flag_q & $past(src_edge)) == $past(src_edge)));
endmodule

// File: rtl/vpic_arb.sv
module vpic_arb #(
  parameter int unsigned NS = 5,
  localparam int unsigned VW = $clog2(NS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NS-1:0] req,
  output logic [NS-1:0] grant,
  output logic          any_req,
  output logic [VW-1:0] vec
);
  logic [NS:0] below;
  assign below[0] = 1'b0;

  // priority chain: a request wins only if nothing below it is asking
  for (genvar g = 0; g < NS; g++) begin : g_chain
    assign grant[g]     = req[g] & ~below[g];
    assign below[g + 1] = below[g] | req[g];
  end

  assign any_req = below[NS];

  always_comb begin
    vec = '0;
    for (int i = 0; i < NS; i++)
      if (grant[i]) vec = VW'(i + 1);
  end

  assert_grant_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_grant_lowest_R1: assert property (@(posedge clk) disable iff (!rst_n)
    any_req |-> (grant == (req & (~req + 1'b1))));
endmodule

// File: rtl/vpic_seq.sv
module vpic_seq
  import vpic_pkg::*;
#(
  parameter int unsigned VW        = 3,
  parameter int unsigned ENTRY_CYC = 4,
  parameter int unsigned WAKE_CYC  = 4,
  parameter int unsigned RET_CYC   = 4,
  localparam int unsigned CW = $clog2(ENTRY_CYC + WAKE_CYC + RET_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          any_req,
  input  logic [VW-1:0] vec_in,
  input  logic          insn_end,
  input  logic          mc_busy,
  input  logic          sleeping,
  input  logic          gie_set,
  input  logic          gie_clr,
  input  logic          reti,
  output logic          take,
  output logic          ack_q,
  output logic [VW-1:0] vec_q,
  output logic          busy,
  output logic          vec_go,
  output logic          sp_pop,
  output logic          gie_q
);
  phase_t        phase;
  logic [CW-1:0] cnt;
  logic          is_idle, seq_last, ret_end, at_boundary;

  assign is_idle     = (phase == PH_IDLE);
  assign at_boundary = sleeping | (insn_end & ~mc_busy);
  assign take        = any_req & gie_q & ~gie_clr & is_idle & ~reti & at_boundary;
  assign seq_last    = ~is_idle & (cnt == '0);
  assign ret_end     = (phase == PH_RET) & seq_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      ack_q <= 1'b0;
      vec_q <= '0;
      gie_q <= 1'b0;
    end else begin
      ack_q <= take;
      if (take) begin
        phase <= PH_ENTRY;
        cnt   <= CW'(entry_len(ENTRY_CYC, WAKE_CYC, sleeping) - 1);
        vec_q <= vec_in;
      end else if (is_idle && reti) begin
        phase <= PH_RET;
        cnt   <= CW'(RET_CYC - 1);
      end else if (seq_last) begin
        phase <= PH_IDLE;
      end else if (!is_idle) begin
        cnt <= cnt - 1'b1;
      end
      if (take || gie_clr)        gie_q <= 1'b0;
      else if (gie_set || ret_end) gie_q <= 1'b1;
    end
  end

  assign busy   = ~is_idle;
  assign vec_go = (phase == PH_ENTRY) & (cnt == '0);
  assign sp_pop = (phase == PH_RET) & (cnt >= CW'(RET_CYC - 2));

  assert_take_drops_gie_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (ack_q && !gie_q && busy));

  assert_clr_blocks_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
    gie_clr |-> !take);

  assert_mc_blocks_take_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_busy && !sleeping) |-> !take);

  assert_entry_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ENTRY) |-> (cnt < CW'(ENTRY_CYC + WAKE_CYC)));

  assert_ret_sets_gie_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ret_end |=> gie_q);

  assert_gie_rise_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gie_q) |-> ($past(gie_set) || $past(ret_end)));
endmodule

// File: rtl/vpic_ctrl.sv
module vpic_ctrl #(
  parameter int unsigned NUM_EDGE  = 3,
  parameter int unsigned NUM_LEVEL = 2,
  parameter int unsigned ENTRY_CYC = 4,
  parameter int unsigned WAKE_CYC  = 4,
  parameter int unsigned RET_CYC   = 4,
  localparam int unsigned NS = NUM_EDGE + NUM_LEVEL,
  localparam int unsigned VW = $clog2(NS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_EDGE-1:0]  src_edge,
  input  logic [NUM_LEVEL-1:0] src_level,
  input  logic                 en_we,
  input  logic [NS-1:0]        en_wdata,
  input  logic [NUM_EDGE-1:0]  flag_clr,
  input  logic                 insn_end,
  input  logic                 mc_busy,
  input  logic                 sleeping,
  input  logic                 gie_set,
  input  logic                 gie_clr,
  input  logic                 reti,
  output logic                 irq_ack,
  output logic [VW-1:0]        irq_vec,
  output logic                 seq_busy,
  output logic                 vec_go,
  output logic                 sp_pop,
  output logic                 gie,
  output logic [NUM_EDGE-1:0]  flags
);
  logic [NS-1:0] req, grant, acc_oh;
  logic          any_req, take;
  logic [VW-1:0] win_vec;

  assign acc_oh = grant & {NS{take}};

  vpic_flags #(.NE(NUM_EDGE), .NL(NUM_LEVEL)) u_flags (
    .clk(clk), .rst_n(rst_n), .src_edge(src_edge), .src_level(src_level),
    .flag_clr(flag_clr), .en_we(en_we), .en_wdata(en_wdata), .acc_oh(acc_oh),
    .flag_q(flags), .req(req)
  );

  vpic_arb #(.NS(NS)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(req), .grant(grant), .any_req(any_req), .vec(win_vec)
  );

  vpic_seq #(.VW(VW), .ENTRY_CYC(ENTRY_CYC), .WAKE_CYC(WAKE_CYC), .RET_CYC(RET_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .any_req(any_req), .vec_in(win_vec),
    .insn_end(insn_end), .mc_busy(mc_busy), .sleeping(sleeping),
    .gie_set(gie_set), .gie_clr(gie_clr), .reti(reti),
    .take(take), .ack_q(irq_ack), .vec_q(irq_vec), .busy(seq_busy),
    .vec_go(vec_go), .sp_pop(sp_pop), .gie_q(gie)
  );

  assert_vec_nonzero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> (irq_vec != '0));
endmodule

// File: tb/vpic_ctrl_tb.sv
module vpic_ctrl_tb;
  localparam int NE = 3, NL = 2, NS = 5, VW = 3;
  localparam int ENT = 4, WAKE = 4, RET = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic [NE-1:0] src_edge, flag_clr, flags;
  logic [NL-1:0] src_level;
  logic en_we, insn_end, mc_busy, sleeping, gie_set, gie_clr, reti;
  logic [NS-1:0] en_wdata;
  logic irq_ack, seq_busy, vec_go, sp_pop, gie;
  logic [VW-1:0] irq_vec;
  int tests = 0, fails = 0, cyc = 0;

  always #4 clk = ~clk;

  vpic_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .src_edge(src_edge), .src_level(src_level),
    .en_we(en_we), .en_wdata(en_wdata), .flag_clr(flag_clr), .insn_end(insn_end),
    .mc_busy(mc_busy), .sleeping(sleeping), .gie_set(gie_set), .gie_clr(gie_clr),
    .reti(reti), .irq_ack(irq_ack), .irq_vec(irq_vec), .seq_busy(seq_busy),
    .vec_go(vec_go), .sp_pop(sp_pop), .gie(gie), .flags(flags)
  );

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic int lowest_vec(logic [NS-1:0] r);
    for (int i = NS - 1; i >= 0; i--) if (r[i]) lowest_vec = i + 1;
  endfunction

  // count busy cycles of a sequence whose first cycle was just sampled
  task automatic run_seq(output int len, output int go_at, output int pops);
    len = 1; go_at = vec_go ? 1 : 0; pops = sp_pop ? 1 : 0;
    while (len < 40) begin
      tick();
      if (!seq_busy) break;
      len++;
      if (vec_go) go_at = len;
      if (sp_pop) pops++;
    end
  endtask

  task automatic do_return(string rq);
    int l, g, p;
    reti = 1; tick(); reti = 0;
    run_seq(l, g, p);
    chk({rq, " return length"}, l, RET);
    chk({rq, " pops"}, p, 2);
    chk({rq, " gie after return"}, gie, 1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      fails++;
      $display("FAIL watchdog (all) actual=%0d expected=<50000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int l, g, p, ev;
    logic [NE-1:0] ef;
    src_edge = 0; src_level = 0; flag_clr = 0; en_we = 0; en_wdata = 0;
    insn_end = 0; mc_busy = 0; sleeping = 0; gie_set = 0; gie_clr = 0; reti = 0;
    rst_n = 0;
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R11
    chk("R11 gie", gie, 0); chk("R11 flags", flags, 0);
    chk("R11 ack", irq_ack, 0); chk("R11 busy", seq_busy, 0);
    // R11: enables start clear, so a flagged event with gie set is not taken
    src_edge = 3'b001; tick(); src_edge = 0;
    gie_set = 1; tick(); gie_set = 0;
    insn_end = 1; tick(); insn_end = 0;
    chk("R11 enables clear", irq_ack, 0);
    gie_clr = 1; flag_clr = '1; tick(); gie_clr = 0; flag_clr = 0;

    en_we = 1; en_wdata = '1; tick(); en_we = 0;

    // R1/R2/R3/R6/R8/R9: sweep every request pattern
    for (int pat = 1; pat < 32; pat++) begin
      logic [NS-1:0] pv;
      pv = NS'(pat);
      src_edge = pv[NE-1:0]; src_level = pv[NS-1:NE]; tick(); src_edge = 0;
      gie_set = 1; insn_end = 1; tick(); gie_set = 0;
      chk("R6 no take at sei boundary", irq_ack, 0);
      chk("R6 gie set", gie, 1);
      tick(); insn_end = 0;
      ev = lowest_vec(pv);
      chk("R1 ack", irq_ack, 1);
      chk("R1 vector", irq_vec, ev);
      chk("R2 gie cleared", gie, 0);
      ef = pv[NE-1:0];
      if (ev <= NE) ef[ev - 1] = 1'b0;
      chk("R3 accepted flag cleared", flags, ef);
      run_seq(l, g, p);
      chk("R8 entry length", l, ENT);
      chk("R8 go at last cycle", g, ENT);
      chk("R2 ack one cycle", irq_ack, 0);
      do_return("R9");
      src_level = 0; flag_clr = '1; gie_clr = 1; tick(); flag_clr = 0; gie_clr = 0;
      chk("R3 write-one clears", flags, 0);
    end

    // R6: after a return, the resumed instruction runs before a take
    src_edge = 3'b010; gie_set = 1; insn_end = 1; tick(); src_edge = 0; gie_set = 0;
    src_edge = 3'b001; tick(); src_edge = 0;
    chk("R6 first take", irq_vec, 2);
    run_seq(l, g, p);
    reti = 1; tick(); reti = 0;
    while (seq_busy) begin
      chk("R6 no take during return", irq_ack, 0);
      tick();
    end
    chk("R6 gie up, no take yet", irq_ack, 0);
    tick();
    chk("R6 take after one instruction", irq_ack, 1);
    chk("R6 vector", irq_vec, 1);
    insn_end = 0;
    run_seq(l, g, p);
    do_return("R6");
    gie_clr = 1; tick(); gie_clr = 0;

    // R7: clear in same cycle as a boundary blocks acceptance
    src_edge = 3'b001; gie_set = 1; tick(); src_edge = 0; gie_set = 0;
    gie_clr = 1; insn_end = 1; tick(); gie_clr = 0; insn_end = 0;
    chk("R7 no take", irq_ack, 0); chk("R7 gie", gie, 0); chk("R7 flag kept", flags, 3'b001);

    // R10: multi-cycle instruction defers the take
    gie_set = 1; tick(); gie_set = 0;
    insn_end = 1; mc_busy = 1;
    for (int k = 0; k < 3; k++) begin tick(); chk("R10 blocked", irq_ack, 0); end
    mc_busy = 0; tick(); insn_end = 0;
    chk("R10 taken", irq_ack, 1); chk("R10 vector", irq_vec, 1);
    run_seq(l, g, p);
    do_return("R10");
    gie_clr = 1; tick(); gie_clr = 0;

    // R8: wake from sleep lengthens entry
    src_edge = 3'b010; gie_set = 1; tick(); src_edge = 0; gie_set = 0;
    sleeping = 1; tick(); sleeping = 0;
    chk("R8 wake take", irq_ack, 1); chk("R8 wake vector", irq_vec, 2);
    run_seq(l, g, p);
    chk("R8 wake length", l, ENT + WAKE); chk("R8 wake go", g, ENT + WAKE);
    do_return("R8");

    // R5: level request gone before enable is never taken
    en_we = 1; en_wdata = 5'b10111; tick(); en_we = 0;
    src_level = 2'b01; insn_end = 1; tick();
    chk("R5 disabled level", irq_ack, 0);
    src_level = 0; tick();
    en_we = 1; en_wdata = '1; tick(); en_we = 0;
    tick();
    chk("R5 vanished level", irq_ack, 0);
    src_level = 2'b01; tick(); insn_end = 0;
    chk("R5 present level", irq_ack, 1); chk("R5 vector", irq_vec, 4);
    run_seq(l, g, p);
    do_return("R5");
    src_level = 0; gie_clr = 1; tick(); gie_clr = 0;

    // R4: flag set while disabled, served once enabled
    en_we = 1; en_wdata = '0; tick(); en_we = 0;
    src_edge = 3'b100; tick(); src_edge = 0;
    chk("R4 flag latched", flags, 3'b100);
    gie_set = 1; insn_end = 1; tick(); gie_set = 0;
    tick(); insn_end = 0;
    chk("R4 not taken while disabled", irq_ack, 0);
    en_we = 1; en_wdata = '1; tick(); en_we = 0;
    insn_end = 1; tick(); insn_end = 0;
    chk("R4 taken later", irq_ack, 1); chk("R4 vector", irq_vec, 3);
    run_seq(l, g, p);
    do_return("R4");
    gie_clr = 1; tick(); gie_clr = 0;

    // R3: clear corner cases
    src_edge = 3'b011; tick(); src_edge = 0;
    src_edge = 3'b001; flag_clr = 3'b001; tick(); src_edge = 0; flag_clr = 0;
    chk("R3 event beats clear", flags, 3'b011);
    flag_clr = 3'b100; tick(); flag_clr = 0;
    chk("R3 zero bits keep flags", flags, 3'b011);
    flag_clr = 3'b011; tick(); flag_clr = 0;
    chk("R3 clear both", flags, 3'b000);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule